// File: doc/BRIEF.md
# Input Edge Counter and Edge-Time Capture Timer

This block watches one asynchronous input pin and measures it against the system clock in one of two ways. It brings the pin into the clock domain with a flop chain and accepts a transition only when the pin stays at its new level for at least two system clocks. Pulses shorter than that are treated as noise, so the fastest input it can follow is a quarter of the clock rate.

In counting mode, a 16-bit down-counter is armed with a start value. Each accepted edge of the selected kind (rising, falling or both) lowers it by one. When it equals a stop value, the block raises a sticky match flag and disarms itself. On the following cycle the counter is reloaded with the start value. It then ignores the pin until it is armed again. The number of edges counted is the start value minus the stop value.

In timing mode, the counter runs down once per clock and wraps from zero back to the start value. Each accepted edge copies the running count into a capture register and raises a sticky event flag. A newer capture overwrites an older one. Both flags have an enable that gates them onto an interrupt output, and each has its own clear pulse.

Top module: `edge_capture_timer`

## Requirements
- R1: The pin passes through a two-flop synchroniser. A transition is accepted only if the synchronised pin held the old level for two samples and then holds the new level for two samples. A high or low pulse that lasts one clock produces no edge. A level first sampled at clock edge N is acted on at clock edge N+3.
- R2: `edge_sel_i` selects the edge kind: 2'b00 is rising only, 2'b01 is falling only, and 2'b10 or 2'b11 is both edges in counting mode. In timing mode, codes 2'b10 and 2'b11 select rising only.
- R3: An `arm_i` pulse without `disarm_i` loads `count_o` from `start_i` and sets `armed_o`. A `disarm_i` pulse clears `armed_o` and takes priority over `arm_i`. While disarmed, with no reload pending, `count_o` holds its value.
- R4: In counting mode (`time_mode_i`=0), while armed, each accepted edge lowers `count_o` by exactly one.
- R5: In counting mode, while armed, when `count_o` equals `stop_i`, the next clock edge sets `match_flag_o` and clears `armed_o`, and the clock edge after that reloads `count_o` from `start_i`. If `start_i` equals `stop_i`, the match happens right after arming, with no edge needed.
- R6: After a match, accepted edges change neither `count_o` nor `armed_o` until the block is armed again.
- R7: In timing mode (`time_mode_i`=1), while armed, `count_o` drops by one every clock and goes from zero to `start_i`. The count after k clocks from arming is start - (k mod (start+1)).
- R8: In timing mode, while armed, each accepted edge copies into `capture_o` the count held just before the clock edge that acts on it, sets `event_flag_o`, and leaves the counter running. A later capture overwrites `capture_o`. No capture happens while disarmed.
- R9: `match_flag_o` and `event_flag_o` stay set until their clear pulse (`match_clr_i`, `event_clr_i`). If a flag is set and cleared in the same cycle, it stays set. `match_irq_o` and `event_irq_o` equal the flag ANDed with its enable input.
- R10: After reset, `count_o` is 16'hFFFF, `capture_o` is 0, and `armed_o` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous input pin |
| time_mode_i | input | 1 | 0: counting mode, 1: timing mode |
| edge_sel_i | input | 2 | Edge kind select (R2) |
| start_i | input | 16 | Start / reload value |
| stop_i | input | 16 | Stop value for counting mode |
| arm_i | input | 1 | Pulse: load counter and arm |
| disarm_i | input | 1 | Pulse: disarm |
| match_ie_i | input | 1 | Match interrupt enable |
| event_ie_i | input | 1 | Event interrupt enable |
| match_clr_i | input | 1 | Pulse: clear match flag |
| event_clr_i | input | 1 | Pulse: clear event flag |
| count_o | output | 16 | Current counter value |
| capture_o | output | 16 | Last captured count |
| armed_o | output | 1 | Block is armed |
| match_flag_o | output | 1 | Sticky match flag |
| event_flag_o | output | 1 | Sticky capture flag |
| match_irq_o | output | 1 | Match flag gated by its enable |
| event_irq_o | output | 1 | Event flag gated by its enable |

## Verification
The hardest conditions to reach from the ports are the ones that depend on exact pin timing. Two cases matter most. The first is a one-clock glitch on either side of an edge, which must not be counted even though it is followed by a long stable level. The second is the cycle on which the final counted edge reaches the stop value, followed by edges that arrive after the self-disarm. The stimulus drives the pin only on falling clock edges, so every level is sampled a known number of times. The bench records the number of the rising clock edge that samples each change and the one that samples the arm pulse. From those two numbers it predicts each captured value and counter value to the exact clock, including the wrap through zero with a small start value.

// File: rtl/ect_pkg.sv
`timescale 1ns/1ps
package ect_pkg;
  localparam logic [1:0] SEL_RISE = 2'b00;
  localparam logic [1:0] SEL_FALL = 2'b01;

  // Resolve whether a qualified transition is one the current mode wants (R2).
  function automatic logic sel_hit(input logic time_mode, input logic [1:0] sel,
                                   input logic rise, input logic fall);
    if (sel == SEL_FALL) return fall;
    if (sel == SEL_RISE) return rise;
    if (time_mode) return rise;
    return rise | fall;
  endfunction
endpackage

// File: rtl/ect_edge_qual.sv
`timescale 1ns/1ps
module ect_edge_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD        = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HW = 2 * HOLD;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-2:0]          hist_q;
  logic [HW-1:0]          wdw;

  // Synchroniser chain; last stage is the clean sample (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  // Window: low HOLD bits are the newest samples, high HOLD bits the older ones
  assign wdw = {hist_q, sync_q[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= wdw[HW-2:0];
  end

  assign rise_o = (&wdw[HOLD-1:0]) & ~(|wdw[HW-1:HOLD]);
  assign fall_o = ~(|wdw[HOLD-1:0]) & (&wdw[HW-1:HOLD]);
endmodule

// File: rtl/ect_core.sv
`timescale 1ns/1ps
module ect_core import ect_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         time_mode_i,
  input  logic [1:0]   edge_sel_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] stop_i,
  input  logic         arm_i,
  input  logic         disarm_i,
  input  logic         rise_i,
  input  logic         fall_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] capture_o,
  output logic         armed_o,
  output logic         edge_hit_o,
  output logic         match_now_o,
  output logic         cap_now_o,
  output logic         reload_pend_o
);
  logic [W-1:0] cnt_q, cap_q;
  logic         armed_q, pend_q, do_arm;

  // Free-running step for timing mode (R7)
  function automatic logic [W-1:0] time_next(input logic [W-1:0] c, input logic [W-1:0] ld);
    return (c == '0) ? ld : c - W'(1);
  endfunction

  assign edge_hit_o  = sel_hit(time_mode_i, edge_sel_i, rise_i, fall_i);
  assign match_now_o = armed_q & ~time_mode_i & (cnt_q == stop_i);
  assign cap_now_o   = armed_q & time_mode_i & edge_hit_o;
  assign do_arm      = arm_i & ~disarm_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      cap_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= match_now_o;
      if (disarm_i)         armed_q <= 1'b0;
      else if (arm_i)       armed_q <= 1'b1;
      else if (match_now_o) armed_q <= 1'b0;

      if (do_arm || pend_q)                        cnt_q <= start_i;
      else if (armed_q && time_mode_i)             cnt_q <= time_next(cnt_q, start_i);
      else if (armed_q && !match_now_o && edge_hit_o) cnt_q <= cnt_q - W'(1);

      if (cap_now_o) cap_q <= cnt_q;
    end
  end

  assign count_o       = cnt_q;
  assign capture_o     = cap_q;
  assign armed_o       = armed_q;
  assign reload_pend_o = pend_q;
endmodule

// File: rtl/ect_status.sv
`timescale 1ns/1ps
module ect_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] flag_q;

  // Set wins over clear in the same cycle (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= set_i | (flag_q & ~clr_i);
  end

  for (genvar g = 0; g < N; g++) begin : g_irq
    assign irq_o[g] = flag_q[g] & ie_i[g];
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/edge_capture_timer.sv
`timescale 1ns/1ps
module edge_capture_timer #(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD        = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_i,
  input  logic         time_mode_i,
  input  logic [1:0]   edge_sel_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] stop_i,
  input  logic         arm_i,
  input  logic         disarm_i,
  input  logic         match_ie_i,
  input  logic         event_ie_i,
  input  logic         match_clr_i,
  input  logic         event_clr_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] capture_o,
  output logic         armed_o,
  output logic         match_flag_o,
  output logic         event_flag_o,
  output logic         match_irq_o,
  output logic         event_irq_o
);
  localparam int unsigned NFLAG = 2;

  // Named internal events, visible to the bound checker
  logic qual_rise, qual_fall;
  logic edge_hit, match_now, cap_now, reload_pend;
  logic [NFLAG-1:0] flags, irqs;

  ect_edge_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLD(HOLD)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(qual_rise), .fall_o(qual_fall)
  );

  ect_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .time_mode_i(time_mode_i), .edge_sel_i(edge_sel_i),
    .start_i(start_i), .stop_i(stop_i), .arm_i(arm_i), .disarm_i(disarm_i),
    .rise_i(qual_rise), .fall_i(qual_fall), .count_o(count_o), .capture_o(capture_o),
    .armed_o(armed_o), .edge_hit_o(edge_hit), .match_now_o(match_now),
    .cap_now_o(cap_now), .reload_pend_o(reload_pend)
  );

  ect_status #(.N(NFLAG)) u_status (
    .clk(clk), .rst_n(rst_n),
    .set_i({cap_now, match_now}), .clr_i({event_clr_i, match_clr_i}),
    .ie_i({event_ie_i, match_ie_i}), .flag_o(flags), .irq_o(irqs)
  );

  assign match_flag_o = flags[0];
  assign event_flag_o = flags[1];
  assign match_irq_o  = irqs[0];
  assign event_irq_o  = irqs[1];
endmodule

// File: rtl/ect_checker.sv
`timescale 1ns/1ps
module ect_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         arm_i,
  input logic         time_mode_i,
  input logic         match_clr_i,
  input logic [W-1:0] start_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] capture_o,
  input logic         armed_o,
  input logic         match_flag_o,
  input logic         edge_hit,
  input logic         match_now,
  input logic         cap_now,
  input logic         reload_pend
);
  assert_glitch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> !edge_hit);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !arm_i && !reload_pend) |=> $stable(count_o));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !time_mode_i && edge_hit && !match_now && !arm_i)
      |=> count_o == $past(count_o) - W'(1));

  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_now && !arm_i) |=> (!armed_o && match_flag_o));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pend |=> count_o == $past(start_i));

  assert_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && time_mode_i && !arm_i && !reload_pend && count_o != '0)
      |=> count_o == $past(count_o) - W'(1));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && time_mode_i && !arm_i && !reload_pend && count_o == '0)
      |=> count_o == $past(start_i));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |=> capture_o == $past(count_o));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag_o && !match_clr_i) |=> match_flag_o);
endmodule

bind edge_capture_timer ect_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .time_mode_i(time_mode_i),
  .match_clr_i(match_clr_i), .start_i(start_i), .count_o(count_o),
  .capture_o(capture_o), .armed_o(armed_o), .match_flag_o(match_flag_o),
  .edge_hit(edge_hit), .match_now(match_now), .cap_now(cap_now),
  .reload_pend(reload_pend)
);

// File: tb/edge_capture_timer_tb_top.sv
`timescale 1ns/1ps
module edge_capture_timer_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, pin = 1'b0, tmode = 1'b0, arm = 1'b0, disarm = 1'b0;
  logic [1:0] esel = 2'b00;
  logic [15:0] start = 16'd0, stop = 16'd0;
  logic mie = 1'b0, eie = 1'b0, mclr = 1'b0, eclr = 1'b0;
  logic [15:0] count, capture;
  logic armed, mflag, eflag, mirq, eirq;

  edge_capture_timer dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .time_mode_i(tmode), .edge_sel_i(esel),
    .start_i(start), .stop_i(stop), .arm_i(arm), .disarm_i(disarm),
    .match_ie_i(mie), .event_ie_i(eie), .match_clr_i(mclr), .event_clr_i(eclr),
    .count_o(count), .capture_o(capture), .armed_o(armed), .match_flag_o(mflag),
    .event_flag_o(eflag), .match_irq_o(mirq), .event_irq_o(eirq)
  );

  typedef enum {S_CNT, S_CAP, S_ARM, S_MFLG, S_EFLG, S_MIRQ, S_EIRQ} sig_e;
  typedef struct { string req; int due; sig_e sel; logic [15:0] exp; } item_t;
  item_t sb_q[$];

  int cyc = 0, n_chk = 0, n_fail = 0, last_p = 0, last_a = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] actual(sig_e s);
    case (s)
      S_CNT:   return count;
      S_CAP:   return capture;
      S_ARM:   return {15'd0, armed};
      S_MFLG:  return {15'd0, mflag};
      S_EFLG:  return {15'd0, eflag};
      S_MIRQ:  return {15'd0, mirq};
      default: return {15'd0, eirq};
    endcase
  endfunction

  // Expected timing-mode count k clocks after arming (R7)
  function automatic logic [15:0] tcnt(int ld, int k);
    return 16'(ld - (k % (ld + 1)));
  endfunction

  // Driver side: push an expected item, kept in due order
  task automatic expect_at(string req, sig_e s, logic [15:0] e, int due);
    item_t it;
    int idx;
    it.req = req; it.due = due; it.sel = s; it.exp = e;
    idx = sb_q.size();
    for (int i = 0; i < sb_q.size(); i++) if (sb_q[i].due > due) begin idx = i; break; end
    sb_q.insert(idx, it);
  endtask

  // Monitor side: pop and compare everything that is due
  always @(negedge clk) begin
    item_t it;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      it = sb_q.pop_front();
      n_chk++;
      if (actual(it.sel) !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s at cycle %0d: actual %h expected %h",
                 it.req, it.sel.name(), cyc, actual(it.sel), it.exp);
      end
    end
  end

  task automatic wait_n(int n); repeat (n) @(negedge clk); endtask
  task automatic set_pin(logic v); pin = v; last_p = cyc + 1; wait_n(4); endtask
  task automatic do_arm(); arm = 1'b1; wait_n(1); arm = 1'b0; last_a = cyc; endtask
  task automatic pulse_mclr(); mclr = 1'b1; wait_n(1); mclr = 1'b0; endtask
  task automatic pulse_eclr(); eclr = 1'b1; wait_n(1); eclr = 1'b0; endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] cap_e;
    int e;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    // R10 reset state
    expect_at("R10", S_CNT, 16'hFFFF, cyc + 1);
    expect_at("R10", S_CAP, 16'h0000, cyc + 1);
    expect_at("R10", S_ARM, 16'd0, cyc + 1);
    expect_at("R10", S_MFLG, 16'd0, cyc + 1);
    expect_at("R10", S_EFLG, 16'd0, cyc + 1);
    wait_n(2);
    mie = 1'b1; eie = 1'b1;

    // R1 glitch rejection, counting mode, both edges
    esel = 2'b10; start = 16'd20; stop = 16'd0;
    do_arm();
    expect_at("R3", S_ARM, 16'd1, cyc + 1);
    expect_at("R3", S_CNT, 16'd20, cyc + 1);
    pin = 1'b1; wait_n(1); pin = 1'b0; wait_n(6);
    expect_at("R1", S_CNT, 16'd20, cyc + 1);
    pin = 1'b1; wait_n(2); pin = 1'b0; wait_n(6);
    expect_at("R1", S_CNT, 16'd18, cyc + 1);
    wait_n(2);

    // R4/R5/R6: start 10, stop 6, both edges -> four edges counted
    start = 16'h000A; stop = 16'h0006;
    do_arm();
    set_pin(1'b1); expect_at("R4", S_CNT, 16'd9, cyc + 1);
    set_pin(1'b0); expect_at("R4", S_CNT, 16'd8, cyc + 1);
    set_pin(1'b1);
    set_pin(1'b0);
    expect_at("R5", S_CNT, 16'd10, cyc + 3);
    expect_at("R5", S_ARM, 16'd0, cyc + 3);
    expect_at("R5", S_MFLG, 16'd1, cyc + 3);
    expect_at("R9", S_MIRQ, 16'd1, cyc + 3);
    wait_n(3);
    set_pin(1'b1);
    set_pin(1'b0);
    expect_at("R6", S_CNT, 16'd10, cyc + 1);
    expect_at("R6", S_ARM, 16'd0, cyc + 1);
    wait_n(2);

    // R9 masking and clear
    mie = 1'b0;
    expect_at("R9", S_MIRQ, 16'd0, cyc + 2);
    expect_at("R9", S_MFLG, 16'd1, cyc + 2);
    wait_n(3);
    pulse_mclr();
    expect_at("R9", S_MFLG, 16'd0, cyc + 1);
    wait_n(2);
    mie = 1'b1;

    // R2 rising only: start 5, stop 3
    esel = 2'b00; start = 16'd5; stop = 16'd3;
    do_arm();
    set_pin(1'b1); expect_at("R2", S_CNT, 16'd4, cyc + 1);
    set_pin(1'b0); expect_at("R2", S_CNT, 16'd4, cyc + 1);
    set_pin(1'b1);
    expect_at("R5", S_CNT, 16'd5, cyc + 3);
    expect_at("R5", S_MFLG, 16'd1, cyc + 3);
    wait_n(3);
    set_pin(1'b0);
    pulse_mclr();

    // R2 falling only
    esel = 2'b01; stop = 16'd0;
    do_arm();
    set_pin(1'b1); expect_at("R2", S_CNT, 16'd5, cyc + 1);
    set_pin(1'b0); expect_at("R2", S_CNT, 16'd4, cyc + 1);
    wait_n(2);

    // R5 start equals stop: matches with no edge
    start = 16'd7; stop = 16'd7;
    do_arm();
    expect_at("R5", S_ARM, 16'd0, cyc + 3);
    expect_at("R5", S_MFLG, 16'd1, cyc + 3);
    expect_at("R5", S_CNT, 16'd7, cyc + 3);
    wait_n(5);
    pulse_mclr();

    // R7/R8 timing mode, rising
    tmode = 1'b1; esel = 2'b00; start = 16'd1000;
    do_arm();
    set_pin(1'b1);
    cap_e = tcnt(1000, last_p + 2 - last_a);
    expect_at("R8", S_CAP, cap_e, cyc + 1);
    expect_at("R8", S_EFLG, 16'd1, cyc + 1);
    expect_at("R9", S_EIRQ, 16'd1, cyc + 1);
    set_pin(1'b0);
    expect_at("R2", S_CAP, cap_e, cyc + 1);
    set_pin(1'b1);
    cap_e = tcnt(1000, last_p + 2 - last_a);
    expect_at("R8", S_CAP, cap_e, cyc + 1);
    expect_at("R8", S_ARM, 16'd1, cyc + 1);
    expect_at("R7", S_CNT, tcnt(1000, cyc + 2 - last_a), cyc + 2);
    wait_n(3);

    // R2 code 2'b10 in timing mode behaves as rising only
    esel = 2'b10;
    set_pin(1'b0);
    expect_at("R2", S_CAP, cap_e, cyc + 1);
    set_pin(1'b1);
    cap_e = tcnt(1000, last_p + 2 - last_a);
    expect_at("R2", S_CAP, cap_e, cyc + 1);
    wait_n(2);

    // R7 wrap through zero with a small start value
    start = 16'd5;
    do_arm();
    for (int k = 1; k <= 8; k++) expect_at("R7", S_CNT, tcnt(5, cyc + k - last_a), cyc + k);
    wait_n(10);

    // R3 disarm holds the count; R8 no capture while disarmed
    disarm = 1'b1; wait_n(1); disarm = 1'b0;
    e = cyc;
    expect_at("R3", S_CNT, tcnt(5, e - last_a), cyc + 2);
    expect_at("R3", S_CNT, tcnt(5, e - last_a), cyc + 5);
    expect_at("R3", S_ARM, 16'd0, cyc + 2);
    wait_n(6);
    pulse_eclr();
    expect_at("R9", S_EFLG, 16'd0, cyc + 1);
    set_pin(1'b0);
    set_pin(1'b1);
    expect_at("R8", S_CAP, cap_e, cyc + 1);
    expect_at("R8", S_EFLG, 16'd0, cyc + 1);

    while (sb_q.size() > 0) wait_n(1);
    wait_n(2);
    done = 1'b1;
    finish_run();
  end
endmodule